// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the control core of a dual-slope integrating analog-to-digital converter. It repeats a fixed cycle. First an auto-zero interval closes the offset-nulling loop with the input amplifier grounded. Next, the conditioned signal is integrated for a fixed run-up time. Then a known reference discharges the integrator during run-down, and the run-down may extend into an overrange interval. The block drives four analog switch controls: the auto-zero loop, the input connection and two reference current paths. It takes the input polarity from the comparator on the last run-up clock. It finds the zero crossing during run-down as a change of the comparator away from that latched polarity.

A separate counting accumulator measures the run-down length. This block gives it a start strobe when run-down begins and a stop strobe on zero detect. A transfer strobe follows one clock after the stop, and a counter-clear strobe follows the transfer. When the accumulator passes its full-scale count, it raises a count-extend input, and the sequence moves into the overrange interval. If no zero crossing arrives within a bounded window, the conversion ends as an overload with no transfer. All interval lengths are counted in clocks of `clk_i` (nominally a 100 kHz timebase). Each interval length is a parameter.

Top module: `dsadc_seq`

## Requirements
- R1: While `rst_ni` is low and in the first clock after release, the outputs hold the auto-zero pattern (`az_close_o`=1, `inp_conn_o`=0, `ref_a_o`=1, `ref_b_o`=0), and every strobe output and `ovrng_o` is 0.
- R2: Auto-zero lasts exactly AZ_LEN clocks. Run-up then begins on its own, with no external trigger.
- R3: During run-up, `inp_conn_o` is 1 for exactly RU_LEN clocks while `az_close_o`, `ref_a_o` and `ref_b_o` are 0. After run-up, `inp_conn_o` returns to 0.
- R4: The comparator level on the last run-up clock is latched as polarity, with 1 meaning a negative input, and shown on `pol_neg_o`. Through run-down and overrange, `az_close_o`=0 and `inp_conn_o`=0. Both `ref_a_o` and `ref_b_o` are 1 for a negative input and both are 0 for a positive input.
- R5: `cnt_start_o` is a one-clock pulse in the first run-down clock (run-down clock 0), once per conversion.
- R6: If the comparator first differs from the latched polarity in run-down clock k, with k ≤ RD_MAX-2, then `cnt_stop_o` pulses once, in run-down clock k+1.
- R7: `cnt_xfer_o` pulses in the clock after `cnt_stop_o`, and `cnt_clr_o` pulses in the clock after `cnt_xfer_o`.
- R8: A `cnt_ext_i` pulse in run-down clock j, with no zero detected by then, raises `ovrng_o` from clock j+1 until the conversion ends. Zero detection and the RD_MAX bound still apply during overrange.
- R9: When zero detect and `cnt_ext_i` fall in the same clock, the zero detect wins: `ovrng_o` stays 0 and the transfer follows.
- R10: If no zero is detected in run-down clocks 0 to RD_MAX-1, `ovld_o` pulses in clock RD_MAX and `cnt_clr_o` pulses in clock RD_MAX+1. `cnt_stop_o` and `cnt_xfer_o` stay 0 for that conversion.
- R11: In the clock after `cnt_clr_o`, the auto-zero pattern of R1 returns and a new auto-zero interval begins.
- R12: Comparator changes during auto-zero, and during run-up apart from its last clock, produce no strobe and do not change the polarity latched for run-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion timebase clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator level, high when integrator is above threshold |
| cnt_ext_i | input | 1 | Accumulator full-scale passed, request overrange |
| az_close_o | output | 1 | Close the auto-zero loop |
| inp_conn_o | output | 1 | Connect the conditioned signal (0 grounds the amplifier input) |
| ref_a_o | output | 1 | Close reference current path A |
| ref_b_o | output | 1 | Close reference current path B |
| pol_neg_o | output | 1 | Latched polarity, 1 means negative input |
| ovrng_o | output | 1 | Overrange interval active |
| cnt_start_o | output | 1 | Start counting strobe |
| cnt_stop_o | output | 1 | Stop counting strobe (zero detected) |
| cnt_xfer_o | output | 1 | Transfer count to holding latches |
| cnt_clr_o | output | 1 | Clear the counters |
| ovld_o | output | 1 | Conversion ended without zero crossing |

## Verification
In the same clock, the zero detect can meet either the count-extend request or the run-down bound. The bench arranges the comparator flip so that the stop strobe lands in the exact clock where it pulses `cnt_ext_i`. It then expects the transfer two clocks after the flip and `ovrng_o` never raised. A further case places the flip at run-down clock RD_MAX-2, so that the latched zero meets the last allowed clock of the window. There the bench expects a normal transfer and no overload pulse.

// File: rtl/dsadc_pkg.sv
`timescale 1ns/1ps
package dsadc_pkg;

    typedef enum logic [2:0] {
        PH_AZ    = 3'd0,
        PH_RUNUP = 3'd1,
        PH_RUNDN = 3'd2,
        PH_OVRNG = 3'd3,
        PH_XFER  = 3'd4,
        PH_OVLD  = 3'd5,
        PH_CLR   = 3'd6
    } phase_e;

    typedef struct packed {
        logic az;
        logic inp;
        logic ref_a;
        logic ref_b;
    } sw_t;

endpackage

// File: rtl/dsadc_swdec.sv
`timescale 1ns/1ps
module dsadc_swdec
    import dsadc_pkg::*;
(
    input  phase_e phase_i,
    input  logic   neg_i,
    output sw_t    sw_o
);

    always_comb begin
        sw_o = '{az: 1'b1, inp: 1'b0, ref_a: 1'b1, ref_b: 1'b0};
        unique case (phase_i)
            PH_RUNUP: sw_o = '{az: 1'b0, inp: 1'b1, ref_a: 1'b0, ref_b: 1'b0};
            PH_RUNDN,
            PH_OVRNG: sw_o = '{az: 1'b0, inp: 1'b0, ref_a: neg_i, ref_b: neg_i};
            default:  sw_o = '{az: 1'b1, inp: 1'b0, ref_a: 1'b1, ref_b: 1'b0};
        endcase
    end

endmodule

// File: rtl/dsadc_polzero.sv
`timescale 1ns/1ps
module dsadc_polzero (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmp_i,
    input  logic capture_i,
    input  logic track_i,
    output logic neg_o,
    output logic zero_o
);

    typedef struct packed {
        logic neg;
        logic zero;
    } pz_t;

    pz_t pz_d, pz_q;

    always_comb begin
        pz_d      = pz_q;
        pz_d.neg  = capture_i ? cmp_i : pz_q.neg;
        pz_d.zero = track_i & (pz_q.zero | (cmp_i ^ pz_q.neg));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pz_q <= '{neg: 1'b0, zero: 1'b0};
        else         pz_q <= pz_d;
    end

    assign neg_o  = pz_q.neg;
    assign zero_o = pz_q.zero;

    // Once seen, a zero crossing stays latched while tracking.
    assert_zero_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (track_i && zero_o) |=> (zero_o || !track_i));

    // Polarity is frozen throughout run-down and overrange.
    assert_pol_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (track_i && $past(track_i)) |-> $stable(neg_o));

endmodule

// File: rtl/dsadc_seq.sv
`timescale 1ns/1ps
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int AZ_LEN = 5000,
    parameter int RU_LEN = 10000,
    parameter int RD_MAX = 20000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmp_i,
    input  logic cnt_ext_i,
    output logic az_close_o,
    output logic inp_conn_o,
    output logic ref_a_o,
    output logic ref_b_o,
    output logic pol_neg_o,
    output logic ovrng_o,
    output logic cnt_start_o,
    output logic cnt_stop_o,
    output logic cnt_xfer_o,
    output logic cnt_clr_o,
    output logic ovld_o
);

    localparam int TMAX_A = (AZ_LEN > RU_LEN) ? AZ_LEN : RU_LEN;
    localparam int TMAX   = (TMAX_A > RD_MAX) ? TMAX_A : RD_MAX;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] AZ_END = TW'(AZ_LEN - 1);
    localparam logic [TW-1:0] RU_END = TW'(RU_LEN - 1);
    localparam logic [TW-1:0] RD_END = TW'(RD_MAX - 1);

    typedef struct packed {
        phase_e          ph;
        logic [TW-1:0]   tmr;
        logic            start;
    } seq_t;

    seq_t seq_d, seq_q;
    logic neg, zero, capture, track;
    sw_t  sw;

    assign capture = (seq_q.ph == PH_RUNUP) && (seq_q.tmr == RU_END);
    assign track   = (seq_q.ph == PH_RUNDN) || (seq_q.ph == PH_OVRNG);

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        unique case (seq_q.ph)
            PH_AZ: begin
                if (seq_q.tmr == AZ_END) begin
                    seq_d.ph  = PH_RUNUP;
                    seq_d.tmr = '0;
                end else begin
                    seq_d.tmr = seq_q.tmr + TW'(1);
                end
            end
            PH_RUNUP: begin
                if (seq_q.tmr == RU_END) begin
                    seq_d.ph    = PH_RUNDN;
                    seq_d.tmr   = '0;
                    seq_d.start = 1'b1;
                end else begin
                    seq_d.tmr = seq_q.tmr + TW'(1);
                end
            end
            PH_RUNDN: begin
                if (zero) begin
                    seq_d.ph = PH_XFER;
                end else if (seq_q.tmr == RD_END) begin
                    seq_d.ph = PH_OVLD;
                end else begin
                    seq_d.tmr = seq_q.tmr + TW'(1);
                    if (cnt_ext_i) seq_d.ph = PH_OVRNG;
                end
            end
            PH_OVRNG: begin
                if (zero) begin
                    seq_d.ph = PH_XFER;
                end else if (seq_q.tmr == RD_END) begin
                    seq_d.ph = PH_OVLD;
                end else begin
                    seq_d.tmr = seq_q.tmr + TW'(1);
                end
            end
            PH_XFER,
            PH_OVLD: seq_d.ph = PH_CLR;
            PH_CLR: begin
                seq_d.ph  = PH_AZ;
                seq_d.tmr = '0;
            end
            default: begin
                seq_d.ph  = PH_AZ;
                seq_d.tmr = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{ph: PH_AZ, tmr: '0, start: 1'b0};
        else         seq_q <= seq_d;
    end

    dsadc_polzero u_polzero (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cmp_i     (cmp_i),
        .capture_i (capture),
        .track_i   (track),
        .neg_o     (neg),
        .zero_o    (zero)
    );

    dsadc_swdec u_swdec (
        .phase_i (seq_q.ph),
        .neg_i   (neg),
        .sw_o    (sw)
    );

    assign az_close_o  = sw.az;
    assign inp_conn_o  = sw.inp;
    assign ref_a_o     = sw.ref_a;
    assign ref_b_o     = sw.ref_b;
    assign pol_neg_o   = neg;
    assign ovrng_o     = (seq_q.ph == PH_OVRNG);
    assign cnt_start_o = seq_q.start;
    assign cnt_stop_o  = zero && track;
    assign cnt_xfer_o  = (seq_q.ph == PH_XFER);
    assign cnt_clr_o   = (seq_q.ph == PH_CLR);
    assign ovld_o      = (seq_q.ph == PH_OVLD);

    assert_inp_az_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inp_conn_o |-> !az_close_o);

    assert_refb_with_refa_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_b_o |-> ref_a_o);

    assert_start_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_start_o |=> !cnt_start_o);

    assert_stop_then_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_stop_o |=> cnt_xfer_o);

    assert_xfer_then_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_xfer_o |=> cnt_clr_o);

    assert_ovrng_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovrng_o |=> (ovrng_o || cnt_xfer_o || ovld_o));

    assert_ovld_no_xfer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovld_o |=> (cnt_clr_o && !cnt_xfer_o));

    assert_timer_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        track |-> (seq_q.tmr <= RD_END));

    assert_clr_then_az_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_clr_o |=> (az_close_o && ref_a_o && !ref_b_o && !inp_conn_o));

endmodule

// File: tb/dsadc_seq_tb_top.sv
`timescale 1ns/1ps
module dsadc_seq_tb_top;

    localparam int AZ_LEN = 12;
    localparam int RU_LEN = 40;
    localparam int RD_MAX = 60;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic cmp_i = 1'b0;
    logic cnt_ext_i = 1'b0;
    logic az_close_o, inp_conn_o, ref_a_o, ref_b_o, pol_neg_o, ovrng_o;
    logic cnt_start_o, cnt_stop_o, cnt_xfer_o, cnt_clr_o, ovld_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    dsadc_seq #(.AZ_LEN(AZ_LEN), .RU_LEN(RU_LEN), .RD_MAX(RD_MAX)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp_i), .cnt_ext_i(cnt_ext_i),
        .az_close_o(az_close_o), .inp_conn_o(inp_conn_o), .ref_a_o(ref_a_o),
        .ref_b_o(ref_b_o), .pol_neg_o(pol_neg_o), .ovrng_o(ovrng_o),
        .cnt_start_o(cnt_start_o), .cnt_stop_o(cnt_stop_o), .cnt_xfer_o(cnt_xfer_o),
        .cnt_clr_o(cnt_clr_o), .ovld_o(ovld_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int az_pattern_ok();
        return (az_close_o === 1'b1 && inp_conn_o === 1'b0 && ref_a_o === 1'b1 &&
                ref_b_o === 1'b0) ? 1 : 0;
    endfunction

    function automatic int strobes_idle();
        return (cnt_start_o === 1'b0 && cnt_stop_o === 1'b0 && cnt_xfer_o === 1'b0 &&
                cnt_clr_o === 1'b0 && ovld_o === 1'b0 && ovrng_o === 1'b0) ? 1 : 0;
    endfunction

    // Starts at the negedge of the first auto-zero clock, returns at the next one.
    task automatic conv(input bit neg, input int zk, input int ek, input bit noise);
        int n = 0;
        int bad = 0;
        int f_stop = -1, f_xfer = -1, f_clr = -1, f_ovld = -1, f_ovr = -1;
        int n_stop = 0, n_start = 0, rd_bad = 0;
        int es, ex, ec, eo, eovr, last_rd;
        string nz = noise ? "R12" : "R11";

        if (zk >= 0) begin
            es = zk + 1; ex = zk + 2; ec = zk + 3; eo = -1; last_rd = zk + 1;
            eovr = (ek >= 0 && ek <= zk) ? ek + 1 : -1;
        end else begin
            es = -1; ex = -1; eo = RD_MAX; ec = RD_MAX + 1; last_rd = RD_MAX - 1;
            eovr = (ek >= 0 && ek <= RD_MAX - 2) ? ek + 1 : -1;
        end

        // auto-zero interval
        while (!inp_conn_o && n <= AZ_LEN + 5) begin
            if (az_pattern_ok() == 0 || strobes_idle() == 0) bad++;
            cmp_i = noise ? ~cmp_i : neg;
            n++;
            @(negedge clk_i);
        end
        chk("R2", "auto-zero length", n, AZ_LEN);
        chk(nz, "auto-zero pattern faults", bad, 0);

        // run-up interval
        n = 0; bad = 0;
        while (inp_conn_o && n <= RU_LEN + 5) begin
            if (az_close_o || ref_a_o || ref_b_o || cnt_stop_o || cnt_start_o) bad++;
            cmp_i = (noise && n != RU_LEN - 1) ? ~cmp_i : neg;
            n++;
            @(negedge clk_i);
        end
        chk("R3", "run-up length", n, RU_LEN);
        chk(noise ? "R12" : "R3", "run-up pattern faults", bad, 0);

        // run-down, overrange and closing strobes
        for (int c = 0; c < RD_MAX + 6; c++) begin
            if (c == 0) chk("R4", "latched polarity", int'(pol_neg_o), int'(neg));
            if (cnt_start_o) n_start++;
            if (c == 0) chk("R5", "start strobe in clock 0", int'(cnt_start_o), 1);
            if (c <= last_rd &&
                (az_close_o || inp_conn_o || ref_a_o !== neg || ref_b_o !== neg)) rd_bad++;
            if (cnt_stop_o) begin n_stop++; if (f_stop < 0) f_stop = c; end
            if (cnt_xfer_o && f_xfer < 0) f_xfer = c;
            if (ovld_o && f_ovld < 0) f_ovld = c;
            if (ovrng_o && f_ovr < 0) f_ovr = c;
            if (cnt_clr_o) begin f_clr = c; break; end
            cmp_i = (zk >= 0 && c >= zk) ? ~neg : neg;
            cnt_ext_i = (c == ek);
            @(negedge clk_i);
        end
        cnt_ext_i = 1'b0;

        chk("R4", "run-down switch faults", rd_bad, 0);
        chk("R5", "start pulses", n_start, 1);
        chk("R6", "stop clock", f_stop, es);
        chk("R6", "stop pulses", n_stop, (zk >= 0) ? 1 : 0);
        chk("R7", "transfer clock", f_xfer, ex);
        chk(ek >= 0 && zk >= 0 && ek == zk + 1 ? "R9" : "R8", "first overrange clock", f_ovr, eovr);
        chk("R10", "overload clock", f_ovld, eo);
        chk(zk >= 0 ? "R7" : "R10", "clear clock", f_clr, ec);

        @(negedge clk_i);
        chk("R11", "auto-zero restored", az_pattern_ok() * strobes_idle(), 1);
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        chk("R1", "pattern in reset", az_pattern_ok() * strobes_idle(), 1);
        rst_ni = 1'b1;
        chk("R1", "pattern at release", az_pattern_ok() * strobes_idle(), 1);
    endtask

    task automatic t_positive();      conv(1'b0, 15, -1, 1'b0);          endtask
    task automatic t_negative();      conv(1'b1, 20, -1, 1'b0);          endtask
    task automatic t_zero_first();    conv(1'b0, 0, -1, 1'b0);           endtask
    task automatic t_overrange();     conv(1'b1, 30, 10, 1'b0);          endtask
    task automatic t_coincide_R9();   conv(1'b0, 25, 26, 1'b0);          endtask
    task automatic t_overload();      conv(1'b1, -1, -1, 1'b0);          endtask
    task automatic t_overload_ovr();  conv(1'b0, -1, 20, 1'b0);          endtask
    task automatic t_latest_zero();   conv(1'b0, RD_MAX - 2, -1, 1'b0);  endtask
    task automatic t_noise_R12();     conv(1'b1, 5, -1, 1'b1);           endtask

    initial begin
        t_reset();
        t_positive();
        t_negative();
        t_zero_first();
        t_overrange();
        t_coincide_R9();
        t_overload();
        t_overload_ovr();
        t_latest_zero();
        t_noise_R12();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5 * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual 0 expected 1 (sequence completion)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule